// File: doc/BRIEF.md
# I2C Slave Status-Code Responder

This block lets a processor act as an addressed target on an I2C bus. The processor programs up to four 7-bit own addresses, each with an enable for general-call recognition, and sets an acknowledge-enable bit. The block watches START and STOP conditions, shifts address and data bytes, drives ACK or NACK, and on every bus event raises an interrupt flag and posts a fixed 8-bit status code. Software reads the code, moves data through a single data register and clears the flag to let the transfer continue.

While the flag is up after a byte-level event, the block holds SCL low. The master's next clock is therefore stalled until software has finished handling the event. In a read transfer, software loads the next byte to send before it clears the flag. If the acknowledge-enable bit is clear when a byte is loaded, that byte is marked as the last one.

The bus inputs are taken to be already synchronous to `clk`. The outputs are open-drain enables: a 1 pulls the line low.

Top module: `i2cs_top`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0xF8, every address slot reads 0x00, and both line-pull outputs are 0.
- R2: While the acknowledge-enable bit (control bit 2) is 0, an address byte is not acknowledged, even if it matches, and the flag stays clear.
- R3: An address byte whose bits 7:1 equal bits 7:1 of any slot (offsets 4 to 7) is acknowledged when its bit 0 is 0 (write). The flag is set and the status becomes 0x60, provided bits 7:1 are not zero.
- R4: The address byte 0x00 is acknowledged with status 0x70 only when bit 0 of some slot is 1. A slot that holds address 0 never produces an own-address match.
- R5: A matched address byte with bit 0 at 1 (read) gives status 0xA8. After software writes the data register (offset 3) and clears the flag, the byte is driven MSB first.
- R6: A data byte received while addressed is acknowledged if acknowledge-enable is 1 and NACKed otherwise. It is readable at offset 3 and reports 0x80 after an own address or 0x90 after general call. After a NACK the block ignores the bus until the next START.
- R7: After a transmitted byte, the status is 0xB8 if the master acknowledged and acknowledge-enable was 1 at load. It is 0xC8 if the master acknowledged but acknowledge-enable was 0 at load, and 0xC0 if the master did not acknowledge. After 0xC0 or 0xC8 the block releases SDA and ignores clocks until the next START.
- R8: A STOP or repeated START while addressed sets the flag with status 0xA0 and does not hold SCL. When the block is not addressed, neither condition has any effect.
- R9: While the flag is set after an address or data event, SCL is held low. Writing 1 to bit 3 at offset 1 clears the flag and releases SCL.
- R10: The status reads 0xF8 whenever the flag is clear. SDA drive changes only while SCL is low.
- R11: Register map: offset 0 reads the control byte (bit 3 flag, bit 2 acknowledge-enable) and a write sets the bits written as 1. Offset 1 clears bits written as 1. Offset 2 is status, offset 3 is data, and offsets 4 to 7 are address slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level, synchronous to clk |
| sda_i | input | 1 | SDA line level, synchronous to clk |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at reg_addr |

## Verification
A bit-banging master in the bench runs write transfers to each slot, a general call with data, a repeated START, and read transfers that end with ACK, with ACK on a byte marked last, and with NACK. Each outcome is told apart by its status code and by the ACK bit seen on the line. Addresses that must not be acknowledged are tried with acknowledge-enable off, with a non-matching address, with general call disabled, and with an address slot holding zero; these show whether the matcher and the enable gating are separate. Extra clocks after a NACK or a final byte, and a STOP that follows them, show whether the block really drops out of the transfer. A per-clock monitor watches that SDA drive never moves while SCL is high.

// File: rtl/i2cs_pkg.sv
// Package: status codes, control bit positions, register offsets and the
// slave state encoding shared by the responder's modules.
package i2cs_pkg;
    localparam logic [7:0] CODE_OWN_WR  = 8'h60;
    localparam logic [7:0] CODE_GC_WR   = 8'h70;
    localparam logic [7:0] CODE_RX_OWN  = 8'h80;
    localparam logic [7:0] CODE_RX_GC   = 8'h90;
    localparam logic [7:0] CODE_END     = 8'hA0;
    localparam logic [7:0] CODE_OWN_RD  = 8'hA8;
    localparam logic [7:0] CODE_TX_ACK  = 8'hB8;
    localparam logic [7:0] CODE_TX_NACK = 8'hC0;
    localparam logic [7:0] CODE_TX_LAST = 8'hC8;
    localparam logic [7:0] CODE_NONE    = 8'hF8;

    localparam int CTL_ACK_BIT  = 2;
    localparam int CTL_FLAG_BIT = 3;

    localparam int OFS_CTL_SET = 0;
    localparam int OFS_CTL_CLR = 1;
    localparam int OFS_STATUS  = 2;
    localparam int OFS_DATA    = 3;
    localparam int OFS_SLOT0   = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_RX,
        S_RX_ACK,
        S_TX_LOAD,
        S_TX,
        S_TX_ACK
    } slv_state_t;
endpackage

// File: rtl/i2cs_edges.sv
// Bus condition detector: flags SCL edges and START/STOP conditions by
// comparing the current line levels with those of the previous clock.
// Assumes scl_i/sda_i are already synchronous to clk.
module i2cs_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Remember last line levels (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_rise  = !scl_q && scl_i;
        scl_fall  = scl_q && !scl_i;
        start_det = scl_q && scl_i && sda_q && !sda_i;
        stop_det  = scl_q && scl_i && !sda_q && sda_i;
    end
endmodule

// File: rtl/i2cs_match.sv
// Address matcher: compares a received address byte against every slot.
// Slot bits 7:1 hold a 7-bit address, bit 0 enables general call.
// Address zero is reserved for general call and never matches a slot.
module i2cs_match #(
    parameter int N_SLOTS = 4
) (
    input  logic [N_SLOTS-1:0][7:0] slots,
    input  logic [7:0]              addr_byte,
    output logic                    hit_own,
    output logic                    hit_gc
);
    logic [N_SLOTS-1:0] own_eq;
    logic [N_SLOTS-1:0] gc_en;

    // One comparator per slot.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        assign own_eq[i] = (slots[i][7:1] == addr_byte[7:1]);
        assign gc_en[i]  = slots[i][0];
    end

    // Combine slot results.
    assign hit_gc  = (addr_byte == 8'h00) && (|gc_en);
    assign hit_own = (addr_byte[7:1] != 7'd0) && (|own_eq);
endmodule

// File: rtl/i2cs_core.sv
// Slave protocol engine: shifts address/data bytes, drives ACK and
// transmit bits on SDA, and emits one status event per bus event.
// Assumes the owner sets the interrupt flag from ev_valid and holds SCL
// while it is set, so no byte event arrives with the flag pending.
module i2cs_core
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_i,
    input  logic       ack_en,
    input  logic       flag,
    input  logic       hit_own,
    input  logic       hit_gc,
    input  logic [7:0] tx_byte,
    output logic [7:0] shreg,
    output logic       sda_oe,
    output logic       ev_valid,
    output logic [7:0] ev_code,
    output logic       rx_wr
);
    slv_state_t state_q;
    logic [7:0] shreg_q;
    logic [3:0] bitcnt_q;
    logic       gc_q, rd_q, ack_q, last_q, sda_q;
    logic       addressed;

    assign shreg  = shreg_q;
    assign sda_oe = sda_q;
    assign addressed = (state_q != S_IDLE) && (state_q != S_ADDR);

    // Protocol state machine, shifter and event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            gc_q     <= 1'b0;
            rd_q     <= 1'b0;
            ack_q    <= 1'b0;
            last_q   <= 1'b0;
            sda_q    <= 1'b0;
            ev_valid <= 1'b0;
            ev_code  <= CODE_NONE;
            rx_wr    <= 1'b0;
        end else begin
            ev_valid <= 1'b0;
            rx_wr    <= 1'b0;
            if (start_det) begin
                if (addressed) begin
                    ev_valid <= 1'b1;
                    ev_code  <= CODE_END;
                end
                state_q  <= S_ADDR;
                bitcnt_q <= '0;
                sda_q    <= 1'b0;
            end else if (stop_det) begin
                if (addressed) begin
                    ev_valid <= 1'b1;
                    ev_code  <= CODE_END;
                end
                state_q <= S_IDLE;
                sda_q   <= 1'b0;
            end else begin
                unique case (state_q)
                    S_IDLE: ;
                    S_ADDR: begin
                        if (scl_rise) begin
                            shreg_q  <= {shreg_q[6:0], sda_i};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            if (ack_en && (hit_own || hit_gc)) begin
                                sda_q   <= 1'b1;
                                gc_q    <= hit_gc;
                                rd_q    <= shreg_q[0];
                                state_q <= S_ADDR_ACK;
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end
                    end
                    S_ADDR_ACK: begin
                        if (scl_fall) begin
                            sda_q    <= 1'b0;
                            ev_valid <= 1'b1;
                            ev_code  <= rd_q ? CODE_OWN_RD : (gc_q ? CODE_GC_WR : CODE_OWN_WR);
                            state_q  <= rd_q ? S_TX_LOAD : S_RX;
                            bitcnt_q <= '0;
                        end
                    end
                    S_RX: begin
                        if (scl_rise) begin
                            shreg_q  <= {shreg_q[6:0], sda_i};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            sda_q   <= ack_en;
                            ack_q   <= ack_en;
                            state_q <= S_RX_ACK;
                        end
                    end
                    S_RX_ACK: begin
                        if (scl_fall) begin
                            sda_q    <= 1'b0;
                            rx_wr    <= 1'b1;
                            ev_valid <= 1'b1;
                            ev_code  <= gc_q ? CODE_RX_GC : CODE_RX_OWN;
                            state_q  <= ack_q ? S_RX : S_IDLE;
                            bitcnt_q <= '0;
                        end
                    end
                    S_TX_LOAD: begin
                        if (!flag && !ev_valid) begin
                            shreg_q  <= tx_byte;
                            last_q   <= !ack_en;
                            bitcnt_q <= '0;
                            sda_q    <= !tx_byte[7];
                            state_q  <= S_TX;
                        end
                    end
                    S_TX: begin
                        if (scl_fall) begin
                            if (bitcnt_q == 4'd7) begin
                                sda_q   <= 1'b0;
                                state_q <= S_TX_ACK;
                            end else begin
                                shreg_q  <= {shreg_q[6:0], 1'b0};
                                sda_q    <= !shreg_q[6];
                                bitcnt_q <= bitcnt_q + 4'd1;
                            end
                        end
                    end
                    S_TX_ACK: begin
                        if (scl_rise) begin
                            ack_q <= !sda_i;
                        end else if (scl_fall) begin
                            ev_valid <= 1'b1;
                            ev_code  <= !ack_q ? CODE_TX_NACK : (last_q ? CODE_TX_LAST : CODE_TX_ACK);
                            state_q  <= (ack_q && !last_q) ? S_TX_LOAD : S_IDLE;
                        end
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_top.sv
// I2C slave responder top: register file (control set/clear, status,
// data, address slots), interrupt flag and clock-stretch control around
// the protocol engine. Bus inputs are assumed synchronous to clk.
module i2cs_top
    import i2cs_pkg::*;
#(
    parameter  int N_SLOTS = 4,
    localparam int AW      = $clog2(OFS_SLOT0 + N_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata
);
    logic scl_rise, scl_fall, start_det, stop_det;
    logic hit_own, hit_gc;
    logic [7:0] shreg;
    logic ev_valid, rx_wr;
    logic [7:0] ev_code;

    logic flag_q, hold_q, ack_en_q;
    logic [7:0] status_q, data_q;
    logic [N_SLOTS-1:0][7:0] slot_q;

    logic set_wr, clr_wr, data_wr;
    assign set_wr  = reg_wr && (reg_addr == AW'(OFS_CTL_SET));
    assign clr_wr  = reg_wr && (reg_addr == AW'(OFS_CTL_CLR));
    assign data_wr = reg_wr && (reg_addr == AW'(OFS_DATA));

    i2cs_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_match #(.N_SLOTS(N_SLOTS)) u_match (
        .slots(slot_q), .addr_byte(shreg), .hit_own(hit_own), .hit_gc(hit_gc)
    );

    i2cs_core u_core (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_i(sda_i),
        .ack_en(ack_en_q), .flag(flag_q), .hit_own(hit_own), .hit_gc(hit_gc),
        .tx_byte(data_q), .shreg(shreg), .sda_oe(sda_oe),
        .ev_valid(ev_valid), .ev_code(ev_code), .rx_wr(rx_wr)
    );

    // Interrupt flag, stretch hold and status code; hardware beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q   <= 1'b0;
            hold_q   <= 1'b0;
            status_q <= CODE_NONE;
        end else if (ev_valid) begin
            flag_q   <= 1'b1;
            hold_q   <= (ev_code != CODE_END);
            status_q <= ev_code;
        end else if (clr_wr && reg_wdata[CTL_FLAG_BIT]) begin
            flag_q   <= 1'b0;
            hold_q   <= 1'b0;
            status_q <= CODE_NONE;
        end
    end

    // Acknowledge-enable bit via set/clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_en_q <= 1'b0;
        end else if (set_wr && reg_wdata[CTL_ACK_BIT]) begin
            ack_en_q <= 1'b1;
        end else if (clr_wr && reg_wdata[CTL_ACK_BIT]) begin
            ack_en_q <= 1'b0;
        end
    end

    // Data register: received byte wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rx_wr) begin
            data_q <= shreg;
        end else if (data_wr) begin
            data_q <= reg_wdata;
        end
    end

    // Address slot registers, one per slot.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (reg_wr && reg_addr == AW'(OFS_SLOT0 + i)) begin
                slot_q[i] <= reg_wdata;
            end
        end
    end

    // Clock stretch output.
    assign scl_oe = flag_q && hold_q;

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFS_CTL_SET)) begin
            reg_rdata[CTL_FLAG_BIT] = flag_q;
            reg_rdata[CTL_ACK_BIT]  = ack_en_q;
        end else if (reg_addr == AW'(OFS_STATUS)) begin
            reg_rdata = status_q;
        end else if (reg_addr == AW'(OFS_DATA)) begin
            reg_rdata = data_q;
        end
        for (int i = 0; i < N_SLOTS; i++) begin
            if (reg_addr == AW'(OFS_SLOT0 + i)) begin
                reg_rdata = slot_q[i];
            end
        end
    end
endmodule

// File: rtl/i2cs_chk.sv
// Property checker for the responder, attached to every i2cs_top by bind.
// Observes the bus pins, the flag and the status register.
module i2cs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       flag,
    input logic [7:0] status
);
    // R10: SDA drive is frozen while SCL stays high.
    a_r10_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R10: flag clear means the idle status code.
    a_r10_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> (status == 8'hF8));

    // R10: a raised flag carries one of the defined codes.
    a_r10_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (status inside {8'h60, 8'h70, 8'h80, 8'h90, 8'hA0,
                                        8'hA8, 8'hB8, 8'hC0, 8'hC8}));

    // R9: byte-level events stretch SCL as soon as the flag rises.
    a_r9_hold_on_byte_event: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && status != 8'hA0) |-> scl_oe);

    // R8: a bus-condition event never stretches SCL.
    a_r8_no_hold_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && status == 8'hA0) |-> !scl_oe);

    // R9: releasing the flag releases SCL on the next cycle.
    a_r9_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> !scl_oe);
endmodule

bind i2cs_top i2cs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .flag(flag_q), .status(status_q)
);

// File: tb/tb_i2cs_top.sv
`timescale 1ns/1ps
// Bench: bit-banging master plus software register accesses, with
// expected codes and bytes taken from the requirements and a per-clock
// monitor of SDA behaviour while SCL is high.
module tb_i2cs_top;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe;
    logic scl_line, sda_line;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    logic mon_scl = 1'b1, mon_oe = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    i2cs_top dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic expect8(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clr_flag();
        wr(3'd1, 8'h08);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b;
        cyc(H);
        m_scl = 1'b1;
        while (scl_line !== 1'b1) cyc(1);
        cyc(H);
        s = sda_line;
        m_scl = 1'b0;
        cyc(2);
    endtask

    task automatic m_start();
        m_sda = 1'b1; m_scl = 1'b1; cyc(H);
        m_sda = 1'b0; cyc(H);
        m_scl = 1'b0; cyc(H);
    endtask

    task automatic m_rstart();
        m_sda = 1'b1; cyc(H);
        m_scl = 1'b1;
        while (scl_line !== 1'b1) cyc(1);
        cyc(H);
        m_sda = 1'b0; cyc(H);
        m_scl = 1'b0; cyc(H);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; cyc(H);
        m_scl = 1'b1;
        while (scl_line !== 1'b1) cyc(1);
        cyc(H);
        m_sda = 1'b1; cyc(H);
    endtask

    task automatic m_send(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
        cyc(4);
    endtask

    task automatic m_recv(input logic ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(!ack, s);
        m_sda = 1'b1;
        cyc(4);
    endtask

    // Per-clock monitor (R10): SDA drive stable while SCL is high.
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            checks++;
            if (mon_scl && scl_line && (sda_oe !== mon_oe)) begin
                errors++;
                $display("FAIL R10 sda_oe moved with SCL high actual=%0b expected=%0b", sda_oe, mon_oe);
            end
        end
        mon_scl = scl_line;
        mon_oe  = sda_oe;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic a;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        mon_on = 1'b1;

        // R1: reset state
        rd(3'd0, v); expect8("R1", "control", v, 8'h00);
        rd(3'd2, v); expect8("R1", "status", v, 8'hF8);
        rd(3'd4, v); expect8("R1", "slot0", v, 8'h00);
        expect8("R1", "line pulls", {6'd0, scl_oe, sda_oe}, 8'h00);

        // R11: slots programmed and read back
        wr(3'd4, 8'hA0); wr(3'd5, 8'h00); wr(3'd6, 8'h79); wr(3'd7, 8'h22);
        rd(3'd6, v); expect8("R11", "slot2 readback", v, 8'h79);

        // R2: acknowledge-enable clear ignores a matching address
        m_start(); m_send(8'hA0, a);
        expect8("R2", "ack bit", {7'd0, a}, 8'h00);
        rd(3'd0, v); expect8("R2", "control", v, 8'h00);
        m_stop();

        wr(3'd0, 8'h04);
        rd(3'd0, v); expect8("R11", "set strobe", v, 8'h04);

        // R3/R9/R6/R8: own write, data, stop
        m_start(); m_send(8'hA0, a);
        expect8("R3", "ack bit", {7'd0, a}, 8'h01);
        rd(3'd2, v); expect8("R3", "status", v, 8'h60);
        rd(3'd0, v); expect8("R11", "control with flag", v, 8'h0C);
        expect8("R9", "stretch", {7'd0, scl_oe}, 8'h01);
        cyc(10);
        expect8("R9", "stretch held", {7'd0, scl_oe}, 8'h01);
        clr_flag();
        expect8("R9", "stretch released", {7'd0, scl_oe}, 8'h00);
        rd(3'd2, v); expect8("R10", "status after clear", v, 8'hF8);
        m_send(8'hA5, a);
        expect8("R6", "data ack", {7'd0, a}, 8'h01);
        rd(3'd2, v); expect8("R6", "status own data", v, 8'h80);
        rd(3'd3, v); expect8("R6", "data byte", v, 8'hA5);
        clr_flag();
        m_stop();
        rd(3'd2, v); expect8("R8", "stop status", v, 8'hA0);
        expect8("R8", "no stretch", {7'd0, scl_oe}, 8'h00);
        clr_flag();

        // R3: slots 3 and 2
        m_start(); m_send(8'h22, a);
        rd(3'd2, v); expect8("R3", "slot3 status", v, 8'h60);
        clr_flag(); m_stop(); clr_flag();
        m_start(); m_send(8'h78, a);
        rd(3'd2, v); expect8("R3", "slot2 status", v, 8'h60);
        clr_flag(); m_stop(); clr_flag();

        // R3/R8: non-matching address is NACKed, stop is ignored
        m_start(); m_send(8'h44, a);
        expect8("R3", "miss ack bit", {7'd0, a}, 8'h00);
        m_stop();
        rd(3'd0, v); expect8("R8", "unaddressed stop", v, 8'h04);

        // R4/R6/R8/R5/R7: general call, data, repeated start, read
        m_start(); m_send(8'h00, a);
        expect8("R4", "gc ack", {7'd0, a}, 8'h01);
        rd(3'd2, v); expect8("R4", "gc status", v, 8'h70);
        clr_flag();
        m_send(8'h3C, a);
        rd(3'd2, v); expect8("R6", "gc data status", v, 8'h90);
        rd(3'd3, v); expect8("R6", "gc data byte", v, 8'h3C);
        clr_flag();
        m_rstart();
        rd(3'd2, v); expect8("R8", "repeated start status", v, 8'hA0);
        clr_flag();
        m_send(8'hA1, a);
        rd(3'd2, v); expect8("R5", "own read status", v, 8'hA8);
        wr(3'd3, 8'h96); clr_flag();
        m_recv(1'b1, v);
        expect8("R5", "sent byte", v, 8'h96);
        rd(3'd2, v); expect8("R7", "acked status", v, 8'hB8);
        wr(3'd3, 8'h5A); wr(3'd1, 8'h04); clr_flag();
        m_recv(1'b1, v);
        expect8("R5", "last byte", v, 8'h5A);
        rd(3'd2, v); expect8("R7", "last status", v, 8'hC8);
        wr(3'd0, 8'h04); clr_flag();
        expect8("R7", "sda released", {7'd0, sda_oe}, 8'h00);
        m_stop();
        rd(3'd0, v); expect8("R8", "stop after last", v, 8'h04);

        // R7: master NACK then extra clocks
        m_start(); m_send(8'hA1, a);
        wr(3'd3, 8'hC3); clr_flag();
        m_recv(1'b0, v);
        expect8("R5", "nacked byte", v, 8'hC3);
        rd(3'd2, v); expect8("R7", "nack status", v, 8'hC0);
        clr_flag();
        m_recv(1'b0, v);
        expect8("R7", "no drive after nack", v, 8'hFF);
        rd(3'd0, v); expect8("R7", "no event after nack", v, 8'h04);
        m_stop();

        // R6: data NACKed with acknowledge-enable clear, then ignored
        m_start(); m_send(8'hA0, a);
        wr(3'd1, 8'h04); clr_flag();
        m_send(8'h81, a);
        expect8("R6", "data nack", {7'd0, a}, 8'h00);
        rd(3'd2, v); expect8("R6", "nacked data status", v, 8'h80);
        rd(3'd3, v); expect8("R6", "nacked data byte", v, 8'h81);
        wr(3'd0, 8'h04); clr_flag();
        m_send(8'h55, a);
        expect8("R6", "ignored after nack", {7'd0, a}, 8'h00);
        rd(3'd0, v); expect8("R6", "no flag after nack", v, 8'h04);
        m_stop();
        rd(3'd0, v); expect8("R8", "stop after nack", v, 8'h04);

        // R4: general call disabled; zero slot does not match
        wr(3'd6, 8'h78);
        m_start(); m_send(8'h00, a);
        expect8("R4", "gc disabled ack", {7'd0, a}, 8'h00);
        rd(3'd0, v); expect8("R4", "gc disabled flag", v, 8'h04);
        m_stop();

        mon_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule